// File: doc/BRIEF.md
# CAN Transceiver Mode and Stuck-Dominant Supervisor

This block is the digital supervisor of a high-speed CAN physical-layer transceiver. A standby input picks one of two modes. In Normal mode the bus driver, the high-speed receiver and the mid-supply reference may run. In Standby mode only the low-power receiver runs, and a filtered copy of its output tells the host that the bus has woken up. The analog driver, the comparators and the reference are outside the block. They appear here only as enable outputs and comparator inputs.

Two hazards share one timeout counter. In Normal mode, a transmit input that stays low too long cuts the driver off until the input goes high again. In Standby mode, a bus that stays dominant too long forces the receive output recessive until the bus goes recessive again. Everything is also gated by two supply-valid flags. The standby, transmit and both comparator inputs pass through two-flop synchronizers.

Top module: `canPhySupervisor`

## Requirements
- R1: While the synchronized standby input is high (Standby mode), drvEn, hsRxEn and splitEn are all 0.
- R2: In Normal mode with vddOk high, hsRxEn and splitEn are 1, and rxd equals the hsRx comparator bit delayed by two clocks (1 = recessive, 0 = dominant).
- R3: In Normal mode, drvEn is 1 only while no transmit timeout is latched. The latch sets one clock after the counter reaches its terminal count and clears on the first synchronized txd high.
- R4: In Standby mode, a bus that stays dominant until the counter reaches its terminal count latches rxd high. The latch clears on the first synchronized recessive lpRx sample, after which wake-up reporting resumes.
- R5: The timeout counter advances on each synchronized dominant sample (txd low in Normal mode, lpRx low in Standby mode). It returns to 0 on any recessive sample. It saturates at TIMEOUT_US microseconds' worth of clocks.
- R6: drvEn, hsRxEn and splitEn are 0 while vddOk is 0. In Normal mode rxd is 1 while vddOk is 0.
- R7: In Standby mode, rxd goes low only after lpRx has been sampled dominant for FILT_CYCLES consecutive synchronized clocks. It returns high in the same cycle that a recessive sample reaches the synchronizer output.
- R8: drvEn and lpRxEn stay 0 until vddOk and vioOk have both been high together at a clock edge. After that, lpRxEn is 1 throughout Standby mode regardless of the supply flags.
- R9: A change of the synchronized mode clears the timeout counter, both timeout latches and the wake filter on that clock.
- R10: After reset the block is in Standby mode with drvEn, hsRxEn, splitEn and lpRxEn at 0 and rxd at 1.
- R11: stby, txd, hsRx and lpRx act two clocks after they are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stby | input | 1 | Mode select, 1 = Standby |
| txd | input | 1 | Transmit data, 0 = dominant |
| hsRx | input | 1 | High-speed comparator, 0 = dominant |
| lpRx | input | 1 | Low-power comparator, 0 = dominant |
| vddOk | input | 1 | Main supply valid |
| vioOk | input | 1 | I/O supply valid |
| drvEn | output | 1 | Bus driver enable |
| rxd | output | 1 | Receive data to the host, 0 = dominant |
| splitEn | output | 1 | Mid-supply reference enable |
| hsRxEn | output | 1 | High-speed receiver enable |
| lpRxEn | output | 1 | Low-power receiver enable |

## Verification
A mode change and a timeout expiry can reach the control logic on the same clock. In that case the clear from the mode change must win over the latch set. The bench holds txd low and then toggles stby at a sweep of offsets around the terminal count, so that the synchronized mode change lands before, on and after the expiry edge. Every output is compared on every clock against a behavioural model. That model decides whether the driver latch or the bus latch may set.

// File: rtl/canSupPkg.sv
package canSupPkg;
  typedef struct packed {
    logic clrTimer;   // restart timeout counter
    logic domSample;  // current sample is dominant for the active mode
    logic filtRun;    // wake filter may advance
  } supStrobe_t;
endpackage

// File: rtl/canSupSync.sv
module canSupSync #(
  parameter int W = 4,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1[i] <= INIT[i];
        dout[i]   <= INIT[i];
      end else begin
        stage1[i] <= din[i];
        dout[i]   <= stage1[i];
      end
    end
  end
endmodule

// File: rtl/canSupPath.sv
module canSupPath
  import canSupPkg::*;
#(
  parameter int LIMIT = 50000,
  parameter int FILT  = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  supStrobe_t strb,
  output logic       expired,
  output logic       filtDone
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam int FW = $clog2(FILT + 1);
  localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
  localparam logic [FW-1:0] FILT_V = FW'(FILT);

  logic [CW-1:0] cnt;
  logic [FW-1:0] wakeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (strb.clrTimer || !strb.domSample) cnt <= '0;
    else if (cnt != LIM_V) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wakeCnt <= '0;
    else if (!strb.filtRun) wakeCnt <= '0;
    else if (wakeCnt != FILT_V) wakeCnt <= wakeCnt + 1'b1;
  end

  assign expired  = (cnt == LIM_V);
  assign filtDone = (wakeCnt == FILT_V);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LIM_V); // R5
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.domSample) |=> !expired); // R5
endmodule

// File: rtl/canSupCtrl.sv
module canSupCtrl
  import canSupPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sStby,
  input  logic       sTxd,
  input  logic       sHs,
  input  logic       sLp,
  input  logic       vddOk,
  input  logic       vioOk,
  input  logic       expired,
  input  logic       filtDone,
  output supStrobe_t strb,
  output logic       drvEn,
  output logic       rxd,
  output logic       splitEn,
  output logic       hsRxEn,
  output logic       lpRxEn
);
  logic stbyPrev, pwrSeen, txdStuck, busStuck;
  logic normal, modeChg;

  assign normal  = !sStby;
  assign modeChg = sStby ^ stbyPrev;

  always_comb begin
    strb.clrTimer  = modeChg;
    strb.domSample = normal ? !sTxd : !sLp;
    strb.filtRun   = !normal && !sLp && !modeChg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbyPrev <= 1'b1;
      pwrSeen  <= 1'b0;
      txdStuck <= 1'b0;
      busStuck <= 1'b0;
    end else begin
      stbyPrev <= sStby;
      if (vddOk && vioOk) pwrSeen <= 1'b1;
      // mode change has priority over a same-cycle expiry (R9)
      if (modeChg || sTxd) txdStuck <= 1'b0;
      else if (normal && expired) txdStuck <= 1'b1;
      if (modeChg || sLp) busStuck <= 1'b0;
      else if (!normal && expired) busStuck <= 1'b1;
    end
  end

  assign drvEn   = normal && pwrSeen && vddOk && !txdStuck;
  assign hsRxEn  = normal && vddOk;
  assign splitEn = normal && vddOk;
  assign lpRxEn  = !normal && pwrSeen;
  assign rxd     = normal ? (vddOk ? sHs : 1'b1)
                          : !(pwrSeen && filtDone && !busStuck && !sLp);

  AST_STBY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    sStby |-> (!drvEn && !hsRxEn && !splitEn)); // R1
  AST_SUPPLY_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (drvEn || splitEn || hsRxEn) |-> vddOk); // R6
  AST_TXD_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (txdStuck && sTxd) |=> !txdStuck); // R3
  AST_BUS_RECESSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (sStby && sLp) |-> rxd); // R4
  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    modeChg |=> (!txdStuck && !busStuck)); // R9
endmodule

// File: rtl/canPhySupervisor.sv
module canPhySupervisor
  import canSupPkg::*;
#(
  parameter int CLK_HZ      = 40_000_000,
  parameter int TIMEOUT_US  = 1250,
  parameter int FILT_CYCLES = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic stby,
  input  logic txd,
  input  logic hsRx,
  input  logic lpRx,
  input  logic vddOk,
  input  logic vioOk,
  output logic drvEn,
  output logic rxd,
  output logic splitEn,
  output logic hsRxEn,
  output logic lpRxEn
);
  localparam int LIMIT = (CLK_HZ / 1_000_000) * TIMEOUT_US;

  logic [3:0] syncOut;
  supStrobe_t strb;
  logic expired, filtDone;

  canSupSync #(.W(4), .INIT(4'b1111)) uSync (
    .clk(clk), .rstN(rstN),
    .din({stby, txd, hsRx, lpRx}), .dout(syncOut)
  );

  canSupCtrl uCtrl (
    .clk(clk), .rstN(rstN),
    .sStby(syncOut[3]), .sTxd(syncOut[2]), .sHs(syncOut[1]), .sLp(syncOut[0]),
    .vddOk(vddOk), .vioOk(vioOk), .expired(expired), .filtDone(filtDone),
    .strb(strb), .drvEn(drvEn), .rxd(rxd), .splitEn(splitEn),
    .hsRxEn(hsRxEn), .lpRxEn(lpRxEn)
  );

  canSupPath #(.LIMIT(LIMIT), .FILT(FILT_CYCLES)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .expired(expired), .filtDone(filtDone)
  );
endmodule

// File: tb/sim_canPhySupervisor.sv
`timescale 1ns/1ps
module sim_canPhySupervisor;
  localparam int LIM  = 100;   // 100 MHz, 1 us
  localparam int FILT = 4;

  logic clk = 0, rstN = 0;
  logic stby = 1, txd = 1, hsRx = 1, lpRx = 1, vddOk = 0, vioOk = 0;
  logic drvEn, rxd, splitEn, hsRxEn, lpRxEn;
  int nChecks = 0, nFail = 0, cycles = 0;
  string tag = "R10";
  bit done = 0;

  always #5 clk = ~clk;

  canPhySupervisor #(.CLK_HZ(100_000_000), .TIMEOUT_US(1), .FILT_CYCLES(FILT)) u0 (
    .clk(clk), .rstN(rstN), .stby(stby), .txd(txd), .hsRx(hsRx), .lpRx(lpRx),
    .vddOk(vddOk), .vioOk(vioOk), .drvEn(drvEn), .rxd(rxd), .splitEn(splitEn),
    .hsRxEn(hsRxEn), .lpRxEn(lpRxEn));

  // behavioural reference: input delay queues plus counters
  bit qS[$], qT[$], qH[$], qL[$];
  bit mPrev, mPwr, mT, mB;
  int mCnt, mW;

  task automatic modelReset();
    qS = '{1, 1}; qT = '{1, 1}; qH = '{1, 1}; qL = '{1, 1};
    mPrev = 1; mPwr = 0; mT = 0; mB = 0; mCnt = 0; mW = 0;
  endtask

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      bit s, t, l, nrm, chg, dom;
      s = qS[0]; t = qT[0]; l = qL[0];
      nrm = !s; chg = (s != mPrev);
      dom = nrm ? !t : !l;
      if (chg || t) mT = 0; else if (nrm && mCnt == LIM) mT = 1;
      if (chg || l) mB = 0; else if (!nrm && mCnt == LIM) mB = 1;
      if (chg || !dom) mCnt = 0; else if (mCnt < LIM) mCnt++;
      if (chg || l || nrm) mW = 0; else if (mW < FILT) mW++;
      if (vddOk && vioOk) mPwr = 1;
      mPrev = s;
      void'(qS.pop_front()); qS.push_back(stby);
      void'(qT.pop_front()); qT.push_back(txd);
      void'(qH.pop_front()); qH.push_back(hsRx);
      void'(qL.pop_front()); qL.push_back(lpRx);
    end
  end

  task automatic chk(string name, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s at %0t: actual %b expected %b", tag, name, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rstN && !done) begin
      bit nrm;
      nrm = !qS[0];
      chk("drvEn",   drvEn,   nrm && mPwr && vddOk && !mT);
      chk("hsRxEn",  hsRxEn,  nrm && vddOk);
      chk("splitEn", splitEn, nrm && vddOk);
      chk("lpRxEn",  lpRxEn,  !nrm && mPwr);
      chk("rxd",     rxd,     nrm ? (vddOk ? qH[0] : 1'b1)
                                  : !(mPwr && mW == FILT && !mB && !qL[0]));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    modelReset();
    tick(3);
    rstN = 1;
    // R10 reset state, supplies still low
    tag = "R10"; #2;
    chk("reset rxd", rxd, 1'b1); chk("reset drvEn", drvEn, 1'b0);
    tick(1);
    // R8 standby without valid supplies: no wake report
    tag = "R8"; lpRx = 0; tick(10); lpRx = 1; tick(4);
    vddOk = 1; vioOk = 1; tick(3);
    // R11 and R2: normal mode, rxd follows hsRx
    tag = "R11"; stby = 0; tick(4);
    tag = "R2";
    for (int i = 0; i < 24; i++) begin
      hsRx = i[0] ^ i[2]; txd = i[1]; tick(1);
    end
    hsRx = 1; txd = 1; tick(3);
    // R3 transmit stuck then release
    tag = "R3"; txd = 0; tick(LIM + 10); txd = 1; tick(5);
    // R5 almost-timeout twice, no latch
    tag = "R5"; txd = 0; tick(LIM - 5); txd = 1; tick(1); txd = 0; tick(LIM - 5); txd = 1; tick(3);
    // R6 vddOk drop in normal mode
    tag = "R6"; vddOk = 0; hsRx = 0; tick(5); vddOk = 1; tick(3); hsRx = 1; tick(3);
    vioOk = 0; tick(3); vioOk = 1; tick(2);
    // R1 standby entry
    tag = "R1"; stby = 1; txd = 0; tick(6); txd = 1; tick(2);
    // R7 wake filter: short glitch, then real wake
    tag = "R7"; lpRx = 0; tick(2); lpRx = 1; tick(3);
    lpRx = 0; tick(10); lpRx = 1; tick(3);
    // R8 supplies drop in standby: receiver stays enabled
    tag = "R8"; vddOk = 0; vioOk = 0; lpRx = 0; tick(8); lpRx = 1; tick(2);
    vddOk = 1; vioOk = 1; tick(2);
    // R4 bus stuck dominant in standby then release
    tag = "R4"; lpRx = 0; tick(LIM + 12); lpRx = 1; tick(3); lpRx = 0; tick(8); lpRx = 1; tick(3);
    // R9 mode change meeting expiry, swept over offsets
    tag = "R9";
    for (int off = 0; off < 5; off++) begin
      stby = 0; txd = 1; lpRx = 1; tick(6);
      txd = 0; lpRx = 0; tick(LIM - 2 + off);
      stby = 1; tick(8 + off);
      txd = 1; lpRx = 1; tick(4);
    end
    tick(4);
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1; nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule